// File: doc/BRIEF.md
# Prescaled One-Shot Countdown Timer

This block counts down a programmed number of prescaled ticks and then raises a one-cycle expiry pulse. A free-running prescaler divides the input clock by a power of two. The power is chosen by a small divide-configuration register that uses a compact 3-bit code. The countdown starts when software writes a non-zero value into the initial-count register. From then on, software can poll the remaining count through a read-only current-count register.

Access uses a plain single-cycle register port. A write is taken on any clock edge where `wr_en` is high. A read is combinational from `rd_addr`. There is no data stream at the block's edge, so there is no valid/ready handshake and no back-pressure. Register selection uses `wr_addr`/`rd_addr`: 0 is divide configuration, 1 is initial count, 2 is current count, and 3 is unused.

Top module: `prescaled_oneshot_timer`

## Requirements
- R1: The divide code is {cfg[3], cfg[1:0]}. The tick period is 2^((code+1) mod 8) input clocks, so codes 0..6 give periods 2..128 and code 7 (cfg value 0xB) gives a period of 1.
- R2: A write to address 0 stores only bits 3, 1 and 0. Reading address 0 returns those bits with all other bits zero. The reset value is 0, which gives a period of 2.
- R3: The prescaler counts input clocks from reset. Cycle c after reset (c = 0 in the first cycle after release) is a tick cycle when (c+1) is a multiple of the current period.
- R4: A write of N > 0 to address 1 in cycle L starts the countdown, and a tick in cycle L itself is not counted. `expire_o` is high in the cycle right after the N-th tick cycle that comes after L.
- R5: A write to address 1 while the timer runs drops the pending countdown and restarts it from the new value.
- R6: While running, a read of address 2 in cycle c returns the ticks still to come in cycles c..T, where T is the final tick. This equals ceil((T+1-c)/period). When idle or expired the read returns 0.
- R7: Writes to address 2 and address 3 have no effect on the count or on the expiry time. Address 3 reads as zero.
- R8: `expire_o` lasts exactly one cycle. After it the timer is idle, reading 0, until the next non-zero load.
- R9: Writing 0 to address 1 leaves the timer idle, or stops it if running, and no expiry pulse follows.
- R10: A divide-configuration write in cycle C while running keeps the old period for tick decisions through cycle C and uses the new period from cycle C+1.
- R11: Reading address 1 returns the last value written there, all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 32 | Read data (combinational) |
| expire_o | output | 1 | One-cycle expiry pulse |

## Verification
The bench sweeps all eight divide codes and loads at prescaler phases that are not aligned. A design that counted the tick in the load cycle, or started from the wrong edge, would expire one tick early or late. It reloads mid-run, loads zero mid-run, and writes the read-only count. A wrong design would then fire a stale pulse, fire a spurious pulse, or corrupt the count. It changes the ratio mid-run, which exposes a design that latches the period at load time. It polls the current count at several cycles, which catches rounding down or a non-zero idle value.

// File: rtl/potimer_pkg.sv
package potimer_pkg;
  localparam int CODE_W    = 3;
  localparam int SHIFT_MAX = (1 << CODE_W) - 1;
  localparam int CFG_W     = 4;
  localparam logic [CFG_W-1:0] CFG_KEEP = 4'hB;

  typedef enum logic [1:0] {
    SEL_DIV  = 2'd0,
    SEL_INIT = 2'd1,
    SEL_CUR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  function automatic logic [CODE_W-1:0] cfg_to_shift(input logic [CFG_W-1:0] cfg);
    logic [CODE_W-1:0] code;
    code = {cfg[3], cfg[1:0]};
    return code + CODE_W'(1);
  endfunction
endpackage

// File: rtl/potimer_prescaler.sv
module potimer_prescaler
  import potimer_pkg::*;
#(
  parameter int PRE_W = SHIFT_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] shift_i,
  output logic              tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] bit_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + PRE_W'(1);
  end

  for (genvar i = 0; i < PRE_W; i++) begin : g_bit
    assign bit_ok[i] = pre_q[i] | (shift_i <= CODE_W'(i));
  end

  assign tick_o = &bit_ok;

  // With a period of two or more, ticks never occur on back-to-back cycles.
  a_r3_no_double_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && shift_i != '0 && $past(shift_i) == shift_i && $past(rst_n)) |-> !$past(tick_o));
  // A period of one ticks on every cycle.
  a_r1_unit_period: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i == '0) |-> tick_o);
endmodule

// File: rtl/potimer_regs.sv
module potimer_regs
  import potimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [1:0]        rd_addr,
  input  logic [CNT_W-1:0]  cur_count_i,
  output logic [CNT_W-1:0]  rd_data,
  output logic [CODE_W-1:0] shift_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o
);
  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] init_q;
  reg_sel_e         wsel, rsel;

  assign wsel = reg_sel_e'(wr_addr);
  assign rsel = reg_sel_e'(rd_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      init_q <= '0;
    end else if (wr_en) begin
      if (wsel == SEL_DIV)  cfg_q  <= wr_data[CFG_W-1:0] & CFG_KEEP;
      if (wsel == SEL_INIT) init_q <= wr_data;
    end
  end

  assign shift_o    = cfg_to_shift(cfg_q);
  assign load_o     = wr_en && (wsel == SEL_INIT);
  assign load_val_o = wr_data;

  always_comb begin
    unique case (rsel)
      SEL_DIV:  rd_data = {{(CNT_W-CFG_W){1'b0}}, cfg_q};
      SEL_INIT: rd_data = init_q;
      SEL_CUR:  rd_data = cur_count_i;
      default:  rd_data = '0;
    endcase
  end

  a_r2_cfg_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~CFG_KEEP) == '0);
  a_r10_cfg_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wsel == SEL_DIV) |=> (cfg_q == ($past(wr_data[CFG_W-1:0]) & CFG_KEEP)));
endmodule

// File: rtl/potimer_counter.sv
module potimer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cur_count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] remain_q;
  logic             run_q;
  logic             expire_q;
  logic             last_tick;

  assign last_tick = run_q && tick_i && (remain_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      run_q    <= 1'b0;
      expire_q <= 1'b0;
    end else if (load_i) begin
      remain_q <= load_val_i;
      run_q    <= (load_val_i != '0);
      expire_q <= 1'b0;
    end else if (run_q && tick_i) begin
      remain_q <= remain_q - CNT_W'(1);
      run_q    <= !last_tick;
      expire_q <= last_tick;
    end else begin
      expire_q <= 1'b0;
    end
  end

  assign cur_count_o = run_q ? remain_q : '0;
  assign expire_o    = expire_q;

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |=> !expire_q);
  a_r8_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> (!run_q && cur_count_o == '0));
  a_r9_zero_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && load_val_i == '0) |=> (!run_q && !expire_q));
  a_r4_expire_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expire_q) |-> ($past(tick_i) && !$past(load_i)));
  a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick_i && !load_i) |=> $stable(remain_q));
endmodule

// File: rtl/prescaled_oneshot_timer.sv
module prescaled_oneshot_timer
  import potimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             expire_o
);
  logic [CODE_W-1:0] shift;
  logic              tick;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic [CNT_W-1:0]  cur_count;

  potimer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .cur_count_i (cur_count),
    .rd_data     (rd_data),
    .shift_o     (shift),
    .load_o      (load),
    .load_val_o  (load_val)
  );

  potimer_prescaler #(.PRE_W(SHIFT_MAX)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (shift),
    .tick_o  (tick)
  );

  potimer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .load_i      (load),
    .load_val_i  (load_val),
    .cur_count_o (cur_count),
    .expire_o    (expire_o)
  );
endmodule

// File: tb/prescaled_oneshot_timer_tb.sv
module prescaled_oneshot_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        expire_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_q[$];

  prescaled_oneshot_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .expire_o(expire_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Monitor: pops the scoreboard whenever a pulse appears.
  always @(negedge clk) begin
    if (rst_n && !done && expire_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8/R9 unexpected pulse", cyc, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R4 expiry cycle", cyc, e);
      end
    end
  end

  function automatic int ratio_of(input logic [3:0] cfg);
    int code;
    code = {cfg[3], cfg[1:0]};
    return 1 << ((code + 1) % 8);
  endfunction

  // Expiry cycle for a load in cycle l of n ticks; period r0 through cycle c, r1 after.
  function automatic int expiry_at(input int l, input int n, input int r0, input int c, input int r1);
    int t, cnt, r;
    t = l; cnt = 0;
    while (cnt < n) begin
      t++;
      r = (t <= c) ? r0 : r1;
      if (((t + 1) % r) == 0) cnt++;
    end
    return t + 1;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, output int at);
    step();
    wr_en = 1'b1; wr_addr = a; wr_data = d; at = cyc;
    step();
    wr_en = 1'b0;
  endtask

  task automatic load(input int n, input int r, output int l);
    step();
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = n; l = cyc;
    exp_q.delete();
    if (n != 0) exp_q.push_back(expiry_at(l, n, r, 1 << 30, r));
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v, output int c);
    step();
    rd_addr = a;
    #1;
    v = rd_data; c = cyc;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && exp_q.size() != 0; i++) step();
    check(exp_q.size() == 0, "R4 pulse arrived", exp_q.size(), 0);
    step(); step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int c, l, at, t, r, e;

    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // Reset state
    rd(2'd0, v, c); check(v == 0, "R2 reset cfg", v, 0);
    rd(2'd2, v, c); check(v == 0, "R6 idle count", v, 0);
    check(expire_o == 0, "R8 reset expire", expire_o, 0);

    // R2 masking and R1 code 7 divides by one
    wr(2'd0, 32'hFFFF_FFFF, at);
    rd(2'd0, v, c); check(v == 32'hB, "R2 cfg mask", v, 32'hB);
    load(5, 1, l);
    e = exp_q[0];
    check(e == l + 6, "R1 period one", e, l + 6);
    rd(2'd2, v, c); t = e - 1;
    check(v == (t - c) / 1 + 1, "R6 count ratio1", v, (t - c) + 1);
    wait_idle();
    rd(2'd2, v, c); check(v == 0, "R8 idle after expiry", v, 0);

    // R1/R3/R4: every code, loads at varying phases
    for (int code = 0; code < 7; code++) begin
      logic [3:0] cfg;
      cfg = {code[2], 1'b0, code[1:0]};
      wr(2'd0, {28'b0, cfg}, at);
      r = ratio_of(cfg);
      for (int k = 0; k < code % 3; k++) step();
      load(3, r, l);
      rd(2'd1, v, c); check(v == 3, "R11 init readback", v, 3);
      rd(2'd2, v, c); t = exp_q[0] - 1;
      check(v == (t - c) / r + 1, "R6 count rounded up", v, (t - c) / r + 1);
      wait_idle();
    end

    // R5: reload while running, ratio 4 (cfg 0x1)
    wr(2'd0, 32'h1, at);
    load(10, 4, l);
    repeat (6) step();
    load(2, 4, l);
    rd(2'd2, v, c); t = exp_q[0] - 1;
    check(v == (t - c) / 4 + 1, "R5 restarted count", v, (t - c) / 4 + 1);
    wait_idle();

    // R9: zero load mid-run cancels, no pulse
    load(20, 4, l);
    repeat (5) step();
    load(0, 4, l);
    rd(2'd2, v, c); check(v == 0, "R9 zero load idle", v, 0);
    repeat (120) step();
    check(exp_q.size() == 0, "R9 no pending", exp_q.size(), 0);

    // R7: writes to read-only and unused addresses ignored
    load(8, 4, l);
    repeat (3) step();
    wr(2'd2, 32'd999, at);
    wr(2'd3, 32'd777, at);
    rd(2'd2, v, c); t = exp_q[0] - 1;
    check(v == (t - c) / 4 + 1, "R7 count unchanged", v, (t - c) / 4 + 1);
    rd(2'd3, v, c); check(v == 0, "R7 unused reads zero", v, 0);
    wait_idle();

    // R10: ratio 8 (cfg 0x2) switched to ratio 1 (cfg 0xB) mid-run
    wr(2'd0, 32'h2, at);
    load(6, 8, l);
    repeat (4) step();
    step();
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'hB; at = cyc;
    e = expiry_at(l, 6, 8, at, 1);
    exp_q.delete(); exp_q.push_back(e);
    step();
    wr_en = 1'b0;
    check(e < expiry_at(l, 6, 8, 1 << 30, 8), "R10 earlier expiry", e, 0);
    wait_idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule